// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard logic of a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. Each cycle it takes the two source register numbers of the instruction now in execute. It compares them with the destinations waiting in the execute/memory and memory/writeback pipeline registers. From that it picks, for each ALU operand, whether the value comes from the register file or from one of those two registers. The younger producer wins when both match.

The unit also looks at the instruction in decode and at the instruction held in the decode/execute register. If the held instruction is a load and decode reads its destination, the load data cannot be forwarded in time. The unit then raises a hold: the pipeline keeps the program counter and the fetch/decode register and loads a bubble, with all controls cleared, into decode/execute for that cycle. The bubble moves on by itself, so the hold lasts one cycle. After that, the waiting instruction takes the load data from memory/writeback.

The register file has a single write port, which writes in writeback. Decode reads the file in the same cycle. The unit therefore flags each decode read port whose register is being written that cycle, so the read path can pass the write data through. Register 0 takes no part in any of these decisions.

Top module: `hz_unit`

## Requirements
- R1: When the execute/memory stage has write enable set and its destination equals a nonzero operand source, that operand's select is 2'b10.
- R2: When only the memory/writeback stage (write enable set) matches a nonzero operand source, that operand's select is 2'b01.
- R3: When both stages match the same nonzero source, the select is 2'b10 (the younger result wins).
- R4: A source of register 0 always selects 2'b00, never raises the hold and never sets a read-port bypass flag. A select of 2'b11 never appears.
- R5: A stage whose write enable is clear is ignored, even when its destination matches. With no valid match the select is 2'b00.
- R6: The hold output is 1 when decode/execute holds a load (load flag 1, write enable 1, destination nonzero) and the decode instruction uses rs1 or rs2 (per its use flags) equal to that destination.
- R7: The hold output is 0 when the producer in decode/execute is not a load, or when the matching decode source is flagged unused.
- R8: Read-port bypass flag n is 1 exactly when memory/writeback has write enable set and its destination equals nonzero decode source n.
- R9: Each operand select depends only on its own source number. Operand A and operand B can take different paths in the same cycle.
- R10: In a pipeline that inserts one bubble per hold, a load followed by a dependent instruction raises the hold for exactly one cycle. The dependent instruction then receives select 2'b01 in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_i | input | AW | Operand A source register of the instruction in execute |
| ex_rs2_i | input | AW | Operand B source register of the instruction in execute |
| exm_rd_i | input | AW | Destination held in execute/memory |
| exm_we_i | input | 1 | Write enable held in execute/memory |
| mwb_rd_i | input | AW | Destination held in memory/writeback (the register written this cycle) |
| mwb_we_i | input | 1 | Write enable held in memory/writeback |
| idx_rd_i | input | AW | Destination held in decode/execute |
| idx_we_i | input | 1 | Write enable held in decode/execute |
| idx_ld_i | input | 1 | Decode/execute instruction is a load |
| id_rs1_i | input | AW | First source register of the instruction in decode |
| id_rs2_i | input | AW | Second source register of the instruction in decode |
| id_use1_i | input | 1 | Decode instruction actually reads its first source |
| id_use2_i | input | 1 | Decode instruction actually reads its second source |
| opa_sel_o | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| opb_sel_o | output | 2 | Operand B select, same encoding |
| hold_o | output | 1 | Load-use hold: keep PC and fetch/decode, put a bubble in decode/execute |
| rfb1_o | output | 1 | Pass write data to decode read port 1 |
| rfb2_o | output | 1 | Pass write data to decode read port 2 |

## Verification
The unit holds no state, so a wrong comparison or priority shows at the ports in the same cycle as the input pattern that exposes it. A wrong comparison or priority gives a wrong select code, a hold that is missing or spurious, or a bypass flag that is missing or spurious. The sweeps drive every mix of small register numbers and enables on the forwarding, hold and bypass paths, so each such fault is seen on the first pattern that touches it. A short pipeline sequence in the bench shows that a hold fault changes the timing of the instruction that follows. With such a fault the hold lasts longer than one cycle, or the waiting instruction misses its memory/writeback select, one cycle after the bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source encoding seen by the ALU input multiplexers.
  typedef enum logic [1:0] {
    OPS_RF    = 2'b00,
    OPS_MEMWB = 2'b01,
    OPS_EXMEM = 2'b10
  } opsel_e;

  localparam int unsigned NUM_OPS = 2;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          we_i,
  output logic          hit_o
);
  // Register 0 is hard-wired and never counts as a dependence.
  always_comb begin
    hit_o = we_i && (dst_i == src_i) && (src_i != '0);
  end
endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hz_pkg::*;
(
  input  logic   hit_exm_i,
  input  logic   hit_mwb_i,
  output opsel_e sel_o
);
  // The younger producer (execute/memory) takes priority.
  always_comb begin
    if (hit_exm_i)      sel_o = OPS_EXMEM;
    else if (hit_mwb_i) sel_o = OPS_MEMWB;
    else                sel_o = OPS_RF;
  end
endmodule

// File: rtl/hz_load_gate.sv
module hz_load_gate #(
  parameter int unsigned NS = 2
) (
  input  logic          is_load_i,
  input  logic [NS-1:0] hit_i,
  input  logic [NS-1:0] use_i,
  output logic          hold_o
);
  always_comb begin
    hold_o = is_load_i && |(hit_i & use_i);
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] exm_rd_i,
  input  logic          exm_we_i,
  input  logic [AW-1:0] mwb_rd_i,
  input  logic          mwb_we_i,
  input  logic [AW-1:0] idx_rd_i,
  input  logic          idx_we_i,
  input  logic          idx_ld_i,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic          id_use1_i,
  input  logic          id_use2_i,
  output logic [1:0]    opa_sel_o,
  output logic [1:0]    opb_sel_o,
  output logic          hold_o,
  output logic          rfb1_o,
  output logic          rfb2_o
);
  localparam int unsigned NS = NUM_OPS;

  logic [NS-1:0][AW-1:0] ex_src;
  logic [NS-1:0][AW-1:0] id_src;
  logic [NS-1:0]         id_use;
  logic [NS-1:0]         hit_exm;
  logic [NS-1:0]         hit_mwb;
  logic [NS-1:0]         hit_idx;
  logic [NS-1:0]         hit_wb;
  opsel_e                sel [NS];

  always_comb begin
    ex_src[0] = ex_rs1_i;
    ex_src[1] = ex_rs2_i;
    id_src[0] = id_rs1_i;
    id_src[1] = id_rs2_i;
    id_use[0] = id_use1_i;
    id_use[1] = id_use2_i;
  end

  for (genvar g = 0; g < NS; g++) begin : g_op
    // Execute-stage forwarding compares
    hz_src_match #(.AW(AW)) u_exm (
      .src_i(ex_src[g]), .dst_i(exm_rd_i), .we_i(exm_we_i), .hit_o(hit_exm[g])
    );
    hz_src_match #(.AW(AW)) u_mwb (
      .src_i(ex_src[g]), .dst_i(mwb_rd_i), .we_i(mwb_we_i), .hit_o(hit_mwb[g])
    );
    hz_opnd_sel u_sel (
      .hit_exm_i(hit_exm[g]), .hit_mwb_i(hit_mwb[g]), .sel_o(sel[g])
    );
    // Decode-stage compares: load-use and same-cycle writeback
    hz_src_match #(.AW(AW)) u_idx (
      .src_i(id_src[g]), .dst_i(idx_rd_i), .we_i(idx_we_i), .hit_o(hit_idx[g])
    );
    hz_src_match #(.AW(AW)) u_wb (
      .src_i(id_src[g]), .dst_i(mwb_rd_i), .we_i(mwb_we_i), .hit_o(hit_wb[g])
    );
  end

  hz_load_gate #(.NS(NS)) u_gate (
    .is_load_i(idx_ld_i), .hit_i(hit_idx), .use_i(id_use), .hold_o(hold_o)
  );

  always_comb begin
    opa_sel_o = sel[0];
    opb_sel_o = sel[1];
    rfb1_o    = hit_wb[0];
    rfb2_o    = hit_wb[1];
  end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic [AW-1:0] exm_rd_i,
  input logic          exm_we_i,
  input logic [AW-1:0] mwb_rd_i,
  input logic          mwb_we_i,
  input logic [AW-1:0] idx_rd_i,
  input logic          idx_we_i,
  input logic          idx_ld_i,
  input logic [AW-1:0] id_rs1_i,
  input logic [AW-1:0] id_rs2_i,
  input logic          id_use1_i,
  input logic          id_use2_i,
  input logic [1:0]    opa_sel_o,
  input logic [1:0]    opb_sel_o,
  input logic          hold_o,
  input logic          rfb1_o,
  input logic          rfb2_o
);
  always_comb begin
    a_r1_exm_pick_a: assert (opa_sel_o != 2'b10 ||
      (exm_we_i && exm_rd_i == ex_rs1_i && ex_rs1_i != '0))
      else $error("R1 operand A forwarded from execute/memory without a match");
    a_r1_exm_pick_b: assert (opb_sel_o != 2'b10 ||
      (exm_we_i && exm_rd_i == ex_rs2_i && ex_rs2_i != '0))
      else $error("R1 operand B forwarded from execute/memory without a match");
    a_r2_mwb_pick_a: assert (opa_sel_o != 2'b01 ||
      (mwb_we_i && mwb_rd_i == ex_rs1_i && ex_rs1_i != '0 &&
       !(exm_we_i && exm_rd_i == ex_rs1_i)))
      else $error("R2/R3 operand A memory/writeback pick is wrong");
    a_r4_legal_code: assert (opa_sel_o != 2'b11 && opb_sel_o != 2'b11)
      else $error("R4 illegal select code");
    a_r4_zero_src: assert ((ex_rs1_i != '0 || opa_sel_o == 2'b00) &&
                           (ex_rs2_i != '0 || opb_sel_o == 2'b00))
      else $error("R4 register 0 forwarded");
    a_r6_hold_cause: assert (!hold_o ||
      (idx_ld_i && idx_we_i && idx_rd_i != '0 &&
       ((id_use1_i && id_rs1_i == idx_rd_i) || (id_use2_i && id_rs2_i == idx_rd_i))))
      else $error("R6/R7 hold without a load-use dependence");
    a_r8_bypass_cause: assert (
      (!rfb1_o || (mwb_we_i && mwb_rd_i == id_rs1_i && id_rs1_i != '0)) &&
      (!rfb2_o || (mwb_we_i && mwb_rd_i == id_rs2_i && id_rs2_i != '0)))
      else $error("R8 bypass flag without a writeback match");
  end
endmodule

bind hz_unit hz_unit_chk #(.AW(AW)) u_chk (
  .ex_rs1_i(ex_rs1_i), .ex_rs2_i(ex_rs2_i),
  .exm_rd_i(exm_rd_i), .exm_we_i(exm_we_i),
  .mwb_rd_i(mwb_rd_i), .mwb_we_i(mwb_we_i),
  .idx_rd_i(idx_rd_i), .idx_we_i(idx_we_i), .idx_ld_i(idx_ld_i),
  .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
  .id_use1_i(id_use1_i), .id_use2_i(id_use2_i),
  .opa_sel_o(opa_sel_o), .opb_sel_o(opb_sel_o), .hold_o(hold_o),
  .rfb1_o(rfb1_o), .rfb2_o(rfb2_o)
);

// File: tb/hz_unit_test.sv
module hz_unit_test;
  localparam int AW = 5;

  logic clk;
  logic rst_n;
  logic [AW-1:0] ex_rs1, ex_rs2, exm_rd, mwb_rd, idx_rd, id_rs1, id_rs2;
  logic exm_we, mwb_we, idx_we, idx_ld, id_use1, id_use2;
  logic [1:0] opa, opb;
  logic hold, rfb1, rfb2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  hz_unit #(.AW(AW)) uut (
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .exm_rd_i(exm_rd), .exm_we_i(exm_we),
    .mwb_rd_i(mwb_rd), .mwb_we_i(mwb_we),
    .idx_rd_i(idx_rd), .idx_we_i(idx_we), .idx_ld_i(idx_ld),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .id_use1_i(id_use1), .id_use2_i(id_use2),
    .opa_sel_o(opa), .opb_sel_o(opb), .hold_o(hold),
    .rfb1_o(rfb1), .rfb2_o(rfb2)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int esel(int rs, int ed, int ew, int md, int mw);
    if (rs != 0 && ew != 0 && ed == rs) return 2;
    if (rs != 0 && mw != 0 && md == rs) return 1;
    return 0;
  endfunction

  function automatic string stag(int rs, int ed, int ew, int md, int mw);
    bit he = (ew != 0 && ed == rs);
    bit hm = (mw != 0 && md == rs);
    if (rs == 0) return "R4";
    if (he && hm) return "R3";
    if (he) return "R1";
    if (hm) return "R2";
    if (ed == rs || md == rs) return "R5";
    return "R4";
  endfunction

  task automatic idle_inputs();
    ex_rs1 = '0; ex_rs2 = '0; exm_rd = '0; exm_we = 0; mwb_rd = '0; mwb_we = 0;
    idx_rd = '0; idx_we = 0; idx_ld = 0; id_rs1 = '0; id_rs2 = '0;
    id_use1 = 0; id_use2 = 0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // Idle pattern: everything from register file, no hold
    chk("R4 idle opa", int'(opa), 0);
    chk("R4 idle hold", int'(hold), 0);

    // Forwarding and writeback bypass sweep (R1..R5, R8)
    for (int s1 = 0; s1 < 4; s1++)
      for (int s2 = 0; s2 < 4; s2++)
        for (int ed = 0; ed < 4; ed++)
          for (int md = 0; md < 4; md++)
            for (int en = 0; en < 4; en++) begin
              int ew = en & 1;
              int mw = (en >> 1) & 1;
              ex_rs1 = AW'(s1); ex_rs2 = AW'(s2);
              exm_rd = AW'(ed); exm_we = ew[0];
              mwb_rd = AW'(md); mwb_we = mw[0];
              id_rs1 = AW'(s2); id_rs2 = AW'(s1);
              settle();
              chk(stag(s1, ed, ew, md, mw), int'(opa), esel(s1, ed, ew, md, mw));
              chk(stag(s2, ed, ew, md, mw), int'(opb), esel(s2, ed, ew, md, mw));
              chk("R8 port1", int'(rfb1), (mw != 0 && md == s2 && s2 != 0) ? 1 : 0);
              chk("R8 port2", int'(rfb2), (mw != 0 && md == s1 && s1 != 0) ? 1 : 0);
            end

    // R9: operands take different paths in one cycle
    idle_inputs();
    ex_rs1 = 5'd7; ex_rs2 = 5'd9; exm_rd = 5'd7; exm_we = 1; mwb_rd = 5'd9; mwb_we = 1;
    settle();
    chk("R9 opa", int'(opa), 2);
    chk("R9 opb", int'(opb), 1);
    ex_rs1 = 5'd9; ex_rs2 = 5'd7;
    settle();
    chk("R9 opa swapped", int'(opa), 1);
    chk("R9 opb swapped", int'(opb), 2);

    // Load-use hold sweep (R6, R7, R4)
    idle_inputs();
    for (int rd = 0; rd < 4; rd++)
      for (int fl = 0; fl < 4; fl++)
        for (int r1 = 0; r1 < 4; r1++)
          for (int r2 = 0; r2 < 4; r2++)
            for (int u = 0; u < 4; u++) begin
              int ld = fl & 1;
              int we = (fl >> 1) & 1;
              int u1 = u & 1;
              int u2 = (u >> 1) & 1;
              int e;
              string t;
              idx_rd = AW'(rd); idx_ld = ld[0]; idx_we = we[0];
              id_rs1 = AW'(r1); id_rs2 = AW'(r2);
              id_use1 = u1[0]; id_use2 = u2[0];
              settle();
              e = (ld != 0 && we != 0 && rd != 0 &&
                   ((u1 != 0 && r1 == rd) || (u2 != 0 && r2 == rd))) ? 1 : 0;
              t = (e != 0) ? "R6" : ((rd == 0) ? "R4" : "R7");
              chk(t, int'(hold), e);
            end

    // R10: small pipeline, load r3 ; add r4,r3,r6 ; sub r5,r4,r3
    idle_inputs();
    // c1: load in decode/execute, add in decode
    idx_rd = 5'd3; idx_we = 1; idx_ld = 1;
    id_rs1 = 5'd3; id_rs2 = 5'd6; id_use1 = 1; id_use2 = 1;
    settle();
    chk("R10 hold on load-use", int'(hold), 1);
    // c2: bubble in decode/execute, load in execute/memory, add still in decode
    idx_rd = '0; idx_we = 0; idx_ld = 0;
    exm_rd = 5'd3; exm_we = 1;
    settle();
    chk("R10 hold released after one bubble", int'(hold), 0);
    // c3: add in execute, bubble in execute/memory, load in memory/writeback
    ex_rs1 = 5'd3; ex_rs2 = 5'd6;
    exm_rd = '0; exm_we = 0;
    mwb_rd = 5'd3; mwb_we = 1;
    idx_rd = 5'd4; idx_we = 1; idx_ld = 0;
    id_rs1 = 5'd4; id_rs2 = 5'd3;
    settle();
    chk("R10 load data from memory/writeback", int'(opa), 1);
    chk("R10 other operand from file", int'(opb), 0);
    chk("R7 non-load producer no hold", int'(hold), 0);
    chk("R8 same-cycle write seen in decode", int'(rfb2), 1);
    // c4: sub in execute, add in execute/memory, bubble in memory/writeback
    ex_rs1 = 5'd4; ex_rs2 = 5'd3;
    exm_rd = 5'd4; exm_we = 1;
    mwb_rd = '0; mwb_we = 0;
    idx_rd = '0; idx_we = 0;
    settle();
    chk("R10 sub opa from execute/memory", int'(opa), 2);
    chk("R10 sub opb from file", int'(opb), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule